// File: doc/BRIEF.md
# Transmit Burst Framer

This block sequences one transmit burst of a direct-sequence baseband transmitter. A media access controller raises an enable envelope to request a burst. The block then spends a programmable number of bit times producing the preamble and header. It raises a ready flag and takes the payload serially on a data input. The sampling is paced by a bit clock that the block derives from a 44 MHz master clock at one of four bit rates. Each captured payload bit goes to the downstream encoder on a one-bit output with a single-cycle strobe.

When the enable drops, the block does not stop at once. It stays active for a fixed tail of 4 µs so that the power amplifier can ramp down. The controller lowers the enable before the last payload bit, so exactly one more bit is taken during the tail. The bit rate and the sampling edge are captured when the burst starts. The sequencer has four states. IDLE moves to HEADER on a rising enable edge (the start transition). HEADER moves to PAYLOAD once the header bit count is complete (the header-done transition), or to TAIL on a falling enable (the header-abort transition). PAYLOAD moves to TAIL on a falling enable (the stop transition). TAIL returns to IDLE when the tail count expires (the drain-done transition).

Top module: `tx_burst_framer`

## Requirements
- R1: While reset is asserted and after it is released with the enable low, active_o, ready_o, tx_clk_o and pay_vld_o are all 0.
- R2: A 0-to-1 change of burst_en_i seen while idle makes active_o 1 from the next cycle. A rising edge seen while not idle is ignored. An enable that is already high when the block returns to idle does not start a burst.
- R3: The bit time is fixed by rate_sel_i as follows: code 0 gives 44 cycles (1 Mb/s), code 1 gives 22 cycles (2 Mb/s), code 2 gives 8 cycles (5.5 Mb/s) and code 3 gives 4 cycles (11 Mb/s). tx_clk_o is 1 in the first half of every bit time and 0 in the second half while active, and 0 while idle.
- R4: The header phase lasts hdr_len_i bit times, with a value of 0 treated as 1. ready_o first reads 1 at hdr_len_i × bit time + 1 cycles after the cycle in which the enable rise is applied. hdr_len_i must stay steady during a burst.
- R5: ready_o is 1 exactly while the payload phase runs.
- R6: With fall_edge_i = 0, ser_din_i is sampled at the clock edge where tx_clk_o rises at the end of each payload bit time. With fall_edge_i = 1, it is sampled at the edge where tx_clk_o falls. The sampled bit appears on pay_bit_o with a one-cycle pay_vld_o pulse in the next cycle. Bits are delivered in arrival order.
- R7: A falling enable during the payload phase drops ready_o in the next cycle. Exactly one further bit is captured. active_o stays 1 for 176 cycles after the fall is sampled and then returns to 0.
- R8: A falling enable during the header phase goes straight to the 176-cycle tail. ready_o never rises and no bit is captured.
- R9: rate_sel_i and fall_edge_i are sampled only at the start of a burst. Changes to them during a burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 44 MHz master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_en_i | input | 1 | Transmit enable envelope |
| rate_sel_i | input | 2 | Bit-rate code (see R3) |
| fall_edge_i | input | 1 | 1 = sample payload on the falling bit-clock edge |
| hdr_len_i | input | HDR_W (8) | Preamble plus header length in bit times |
| ser_din_i | input | 1 | Serial payload data, LSB first |
| tx_clk_o | output | 1 | Generated bit clock |
| ready_o | output | 1 | Payload may be sent |
| active_o | output | 1 | Transmitter running (header, payload or tail) |
| pay_bit_o | output | 1 | Last captured payload bit |
| pay_vld_o | output | 1 | One-cycle strobe marking a new pay_bit_o |

## Verification
active_o rises one cycle after the enable rise is sampled. ready_o follows hdr_len_i bit times later. Each pay_vld_o pulse comes one cycle after its sampling edge, and active_o falls 176 cycles after the enable fall is sampled. The bench changes inputs on falling clock edges and runs a behavioural model on rising edges. It compares all five outputs against the model on every falling edge, which places each comparison half a cycle after the register update that produced the value. Scenario checks then measure header latency, tail length and the captured bit sequence by counting falling edges from the stimulus.

// File: rtl/txf_pkg.sv
package txf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HEADER  = 2'd1,
        ST_PAYLOAD = 2'd2,
        ST_TAIL    = 2'd3
    } txf_state_e;

    // Bit time in master-clock cycles for a rate code, given the clock in MHz.
    function automatic int unsigned bit_period(input logic [1:0] code,
                                               input int unsigned clk_mhz);
        int unsigned p;
        case (code)
            2'd0:    p = clk_mhz;
            2'd1:    p = clk_mhz / 2;
            2'd2:    p = (clk_mhz * 2) / 11;
            default: p = clk_mhz / 11;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/txf_edge_detect.sv
module txf_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_i;
        end
    end

    assign rise_o = level_i & ~level_q;
    assign fall_o = ~level_i & level_q;
endmodule

// File: rtl/txf_bit_timer.sv
module txf_bit_timer #(
    parameter int unsigned CLK_MHZ = 44
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [1:0] rate_i,
    input  logic       run_i,
    output logic       bit_end_o,
    output logic       half_end_o,
    output logic       clk_lvl_o
);
    localparam int unsigned CNT_W = $clog2(CLK_MHZ + 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] per_tab [4];
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half;

    for (genvar g = 0; g < 4; g++) begin : g_per
        assign per_tab[g] = CNT_W'(txf_pkg::bit_period(2'(g), CLK_MHZ));
    end

    assign half = per_q >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= CNT_W'(CLK_MHZ);
        end else if (load_i) begin
            per_q <= per_tab[rate_i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == per_q - ONE) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign bit_end_o  = run_i && (cnt_q == per_q - ONE);
    assign half_end_o = run_i && (cnt_q == half - ONE);
    assign clk_lvl_o  = run_i && (cnt_q < half);
endmodule

// File: rtl/txf_seq_fsm.sv
module txf_seq_fsm
    import txf_pkg::*;
#(
    parameter int unsigned HDR_W    = 8,
    parameter int unsigned TAIL_CYC = 176
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             bit_end_i,
    input  logic [HDR_W-1:0] hdr_len_i,
    input  logic             cap_fire_i,
    output logic             start_o,
    output logic             run_o,
    output logic             ready_o,
    output logic             cap_en_o
);
    localparam int unsigned TAIL_W = $clog2(TAIL_CYC);

    txf_state_e      state_q, state_d;
    logic [HDR_W-1:0] bc_q;
    logic [TAIL_W-1:0] tc_q;
    logic            last_q;
    logic [HDR_W:0]  bc_inc;
    logic            hdr_done;
    logic            tail_done;

    assign bc_inc    = {1'b0, bc_q} + (HDR_W+1)'(1);
    assign hdr_done  = bc_inc >= {1'b0, hdr_len_i};
    assign tail_done = (tc_q == TAIL_W'(TAIL_CYC - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (rise_i) state_d = ST_HEADER;
            ST_HEADER: begin
                if (fall_i)                     state_d = ST_TAIL;
                else if (bit_end_i && hdr_done) state_d = ST_PAYLOAD;
            end
            ST_PAYLOAD: if (fall_i) state_d = ST_TAIL;
            ST_TAIL:    if (tail_done) state_d = ST_IDLE;
        endcase
    end

    // Header bit count, tail count and final-bit allowance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bc_q   <= '0;
            tc_q   <= '0;
            last_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    bc_q   <= '0;
                    tc_q   <= '0;
                    last_q <= 1'b0;
                end
                ST_HEADER: begin
                    if (bit_end_i && !hdr_done) bc_q <= bc_q + HDR_W'(1);
                    tc_q   <= '0;
                    last_q <= 1'b0;
                end
                ST_PAYLOAD: begin
                    tc_q   <= '0;
                    last_q <= fall_i;
                end
                ST_TAIL: begin
                    if (!tail_done) tc_q <= tc_q + TAIL_W'(1);
                    if (cap_fire_i) last_q <= 1'b0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        start_o  = 1'b0;
        run_o    = 1'b1;
        ready_o  = 1'b0;
        cap_en_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                run_o   = 1'b0;
                start_o = rise_i;
            end
            ST_HEADER:  ;
            ST_PAYLOAD: begin
                ready_o  = 1'b1;
                cap_en_o = 1'b1;
            end
            ST_TAIL:    cap_en_o = last_q;
        endcase
    end
endmodule

// File: rtl/txf_bit_capture.sv
module txf_bit_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic fall_edge_i,
    input  logic cap_en_i,
    input  logic bit_end_i,
    input  logic half_end_i,
    input  logic din_i,
    output logic fire_o,
    output logic bit_o,
    output logic vld_o
);
    logic mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (load_i) begin
            mode_q <= fall_edge_i;
        end
    end

    assign fire_o = cap_en_i && (mode_q ? half_end_i : bit_end_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_o <= 1'b0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= fire_o;
            if (fire_o) bit_o <= din_i;
        end
    end
endmodule

// File: rtl/tx_burst_framer.sv
module tx_burst_framer #(
    parameter int unsigned CLK_MHZ = 44,
    parameter int unsigned TAIL_US = 4,
    parameter int unsigned HDR_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_en_i,
    input  logic [1:0]       rate_sel_i,
    input  logic             fall_edge_i,
    input  logic [HDR_W-1:0] hdr_len_i,
    input  logic             ser_din_i,
    output logic             tx_clk_o,
    output logic             ready_o,
    output logic             active_o,
    output logic             pay_bit_o,
    output logic             pay_vld_o
);
    localparam int unsigned TAIL_CYC = TAIL_US * CLK_MHZ;

    logic rise, fall, start, run, cap_en, fire, bit_end, half_end;

    txf_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (burst_en_i),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    txf_bit_timer #(.CLK_MHZ(CLK_MHZ)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start),
        .rate_i     (rate_sel_i),
        .run_i      (run),
        .bit_end_o  (bit_end),
        .half_end_o (half_end),
        .clk_lvl_o  (tx_clk_o)
    );

    txf_seq_fsm #(.HDR_W(HDR_W), .TAIL_CYC(TAIL_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .fall_i     (fall),
        .bit_end_i  (bit_end),
        .hdr_len_i  (hdr_len_i),
        .cap_fire_i (fire),
        .start_o    (start),
        .run_o      (run),
        .ready_o    (ready_o),
        .cap_en_o   (cap_en)
    );

    txf_bit_capture u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (start),
        .fall_edge_i (fall_edge_i),
        .cap_en_i    (cap_en),
        .bit_end_i   (bit_end),
        .half_end_i  (half_end),
        .din_i       (ser_din_i),
        .fire_o      (fire),
        .bit_o       (pay_bit_o),
        .vld_o       (pay_vld_o)
    );

    assign active_o = run;
endmodule

// File: rtl/txf_chk.sv
module txf_chk (
    input logic clk,
    input logic rst_n,
    input logic burst_en_i,
    input logic active_o,
    input logic ready_o,
    input logic tx_clk_o,
    input logic pay_vld_o
);
    // R5
    ready_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> active_o);

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_vld_o |=> !pay_vld_o);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (!tx_clk_o && !ready_o));

    // R2
    start_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> $past(burst_en_i));

    // R7
    tail_before_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> !$past(ready_o));

    // R7
    ready_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> !$past(burst_en_i));
endmodule

bind tx_burst_framer txf_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_en_i (burst_en_i),
    .active_o   (active_o),
    .ready_o    (ready_o),
    .tx_clk_o   (tx_clk_o),
    .pay_vld_o  (pay_vld_o)
);

// File: tb/test_tx_burst_framer.sv
`timescale 1ns/1ps
module test_tx_burst_framer;
    localparam int TAIL = 176;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [1:0] rate = 2'd0;
    logic fm = 1'b0;
    logic [7:0] hdr = 8'd1;
    logic din = 1'b0;
    logic tx_clk_o, ready_o, active_o, pay_bit_o, pay_vld_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tx_burst_framer i_tx_burst_framer (
        .clk(clk), .rst_n(rst_n), .burst_en_i(en), .rate_sel_i(rate),
        .fall_edge_i(fm), .hdr_len_i(hdr), .ser_din_i(din),
        .tx_clk_o(tx_clk_o), .ready_o(ready_o), .active_o(active_o),
        .pay_bit_o(pay_bit_o), .pay_vld_o(pay_vld_o)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", what, act, exp, $time);
        end
    endtask

    function automatic int per_of(input int code);
        case (code)
            0: return 44;
            1: return 22;
            2: return 8;
            default: return 4;
        endcase
    endfunction

    // Behavioural reference model: 0 idle, 1 header, 2 payload, 3 tail
    int m_st = 0, m_cnt = 0, m_per = 44, m_bc = 0, m_tc = 0;
    bit m_fm = 0, m_last = 0, m_enq = 0, m_vld = 0, m_bit = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_per = 44; m_bc = 0; m_tc = 0;
            m_fm = 0; m_last = 0; m_enq = 0; m_vld = 0; m_bit = 0;
        end else begin
            bit rise, fll, bend, hend, cap;
            int nst;
            rise = en && !m_enq;
            fll  = !en && m_enq;
            bend = (m_st != 0) && (m_cnt == m_per - 1);
            hend = (m_st != 0) && (m_cnt == m_per / 2 - 1);
            cap  = ((m_st == 2) || (m_st == 3 && m_last)) && (m_fm ? hend : bend);
            m_vld = cap;
            if (cap) m_bit = din;
            nst = m_st;
            case (m_st)
                0: if (rise) begin nst = 1; m_per = per_of(int'(rate)); m_fm = fm; m_bc = 0; end
                1: if (fll) begin nst = 3; m_tc = 0; m_last = 0; end
                   else if (bend) begin
                       if (m_bc + 1 >= int'(hdr)) nst = 2; else m_bc++;
                   end
                2: if (fll) begin nst = 3; m_tc = 0; m_last = 1; end
                default: begin
                    if (cap) m_last = 0;
                    if (m_tc == TAIL - 1) nst = 0; else m_tc++;
                end
            endcase
            if (m_st == 0 || bend) m_cnt = 0; else m_cnt++;
            m_st = nst;
            m_enq = en;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int e_act, e_rdy, e_clk;
            e_act = (m_st != 0);
            e_rdy = (m_st == 2);
            e_clk = (m_st != 0) && (m_cnt < m_per / 2);
            chk(active_o == e_act, "R2 active_o per-cycle", active_o, e_act);
            chk(ready_o == e_rdy, "R5 ready_o per-cycle", ready_o, e_rdy);
            chk(tx_clk_o == e_clk, "R3 tx_clk_o per-cycle", tx_clk_o, e_clk);
            chk(pay_vld_o == m_vld, "R6 pay_vld_o per-cycle", pay_vld_o, m_vld);
            if (m_vld) chk(pay_bit_o == m_bit, "R6 pay_bit_o per-cycle", pay_bit_o, m_bit);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WD_LIMIT);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic burst(input int r, input bit f, input int h, input int nbits,
                         input logic [15:0] pat, input bit disturb, input bit reassert);
        int lat, got, tl, heff;
        logic [15:0] coll;
        heff = (h == 0) ? 1 : h;
        rate = 2'(r); fm = f; hdr = 8'(h);
        got = 0; coll = '0; din = pat[0];
        @(negedge clk);
        en = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (disturb && lat == 2) begin
                rate = ~rate; fm = ~fm;   // R9: must not affect this burst
            end
        end while (!ready_o);
        chk(lat == heff * per_of(r) + 1, disturb ? "R9 header latency after mid-burst rate change"
                                                 : "R4 header latency", lat, heff * per_of(r) + 1);
        while (got < nbits - 1) begin
            @(negedge clk);
            if (pay_vld_o) begin
                coll[got] = pay_bit_o;
                got++;
                din = pat[got];
            end
        end
        en = 1'b0;
        tl = 0;
        do begin
            @(negedge clk);
            if (pay_vld_o) begin coll[got] = pay_bit_o; got++; end
            if (active_o) tl++;
            if (reassert && tl == 20) en = 1'b1;
        end while (active_o);
        chk(tl == TAIL, "R7 tail length", tl, TAIL);
        chk(got == nbits, "R7 bits captured including final", got, nbits);
        chk((coll & 16'((1 << nbits) - 1)) == (pat & 16'((1 << nbits) - 1)),
            "R6 captured sequence", int'(coll), int'(pat & 16'((1 << nbits) - 1)));
        if (reassert) begin
            repeat (40) @(negedge clk);
            chk(active_o == 1'b0, "R2 steady-high enable at idle does not start", active_o, 0);
            en = 1'b0;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic header_abort(input int r, input int h);
        int vcount, rcount, tl;
        rate = 2'(r); fm = 1'b0; hdr = 8'(h);
        vcount = 0; rcount = 0; tl = 0;
        @(negedge clk);
        en = 1'b1;
        repeat (per_of(r) + 3) @(negedge clk);
        en = 1'b0;
        do begin
            @(negedge clk);
            if (pay_vld_o) vcount++;
            if (ready_o) rcount++;
            if (active_o) tl++;
        end while (active_o);
        chk(vcount == 0, "R8 no bit captured after header abort", vcount, 0);
        chk(rcount == 0, "R8 ready never rises after header abort", rcount, 0);
        chk(tl == TAIL, "R8 tail length after header abort", tl, TAIL);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(active_o == 0 && ready_o == 0 && tx_clk_o == 0 && pay_vld_o == 0,
            "R1 outputs during reset", {active_o, ready_o, tx_clk_o, pay_vld_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(active_o == 0 && ready_o == 0 && tx_clk_o == 0 && pay_vld_o == 0,
            "R1 outputs after reset", {active_o, ready_o, tx_clk_o, pay_vld_o}, 0);

        burst(3, 1'b0, 3, 8,  16'h00A5, 1'b0, 1'b0);
        burst(2, 1'b1, 2, 10, 16'h02C7, 1'b0, 1'b0);
        burst(1, 1'b0, 1, 6,  16'h0015, 1'b0, 1'b0);
        burst(0, 1'b1, 2, 5,  16'h000B, 1'b0, 1'b0);
        burst(3, 1'b1, 0, 4,  16'h0009, 1'b0, 1'b0);
        burst(2, 1'b0, 4, 7,  16'h005A, 1'b1, 1'b0);
        burst(3, 1'b0, 2, 3,  16'h0005, 1'b0, 1'b1);
        header_abort(1, 5);
        burst(0, 1'b0, 192, 2, 16'h0002, 1'b0, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule